// File: doc/BRIEF.md
# Serial Display Command Interpreter

This block sits behind the address-match stage of a serial write port for a dot-matrix display controller. It receives the transaction payload one byte at a time, uses prefix bytes to decide what each following byte means, and turns the result into configuration state, window updates and a stream of display data for the address generator. The port is write-only. The block never drives anything back toward the host.

Every byte of a transaction is first read as a prefix. The value 0x80 marks the next byte as one command-channel byte. The value 0xC0 marks the next byte as one data byte. The value 0x40 makes every remaining byte of the transaction data. On the command channel the block decodes opcodes. Some opcodes take one or two argument bytes, and each argument arrives on the command channel behind its own 0x80 prefix. A transaction end always returns the block to prefix reading.

All outputs are registered. A byte accepted on one clock edge is visible at the outputs after that same edge.

Top module: `dispcmd_interp`

## Requirements
- R1: After reset the outputs are:
  - panel off, all-lit override off, normal video, forward scan and forward segment order;
  - brightness 0x7F, line shift 0 and addressing mode 0;
  - column window 0 to 2^COL_W-1 and page window 0 to 2^PAGE_W-1;
  - all strobes low.
- R2: In the prefix phase, a byte of 0x80 routes exactly one following byte to the command decoder. After that byte the parser is back in the prefix phase.
- R3: In the prefix phase, a byte of 0xC0 routes exactly one following byte to the data output. `data_stb` is high for one cycle with that byte on `data_byte`. The parser then returns to the prefix phase.
- R4: In the prefix phase, a byte of 0x40 makes every later byte of the transaction a data byte, whatever its value, until the transaction ends.
- R5: The opcodes below each set one display flag:
  - 0xAE clears `disp_on` and 0xAF sets it;
  - 0xA4 clears `all_on` and 0xA5 sets it;
  - 0xA6 clears `invert` and 0xA7 sets it.
- R6: The opcodes below each set one orientation flag:
  - 0xC0 clears `scan_rev` and 0xC8 sets it;
  - 0xA0 clears `seg_rev` and 0xA1 sets it.
- R7: Opcodes 0x20, 0x81 and 0xD3 each take the next command-channel byte as their argument:
  - 0x20 loads its low 2 bits into `addr_mode`;
  - 0x81 loads the whole byte into `contrast`;
  - 0xD3 loads its low OFS_W bits into `offset`.
- R8: Opcode 0x21 takes a start and an end column from the next two command-channel bytes, and 0x22 does the same for pages. Each value is cut to COL_W or PAGE_W low bits. Start and end change together, in the same cycle that the window's strobe pulses after the end argument. Nothing visible changes after the start argument.
- R9: An opcode not listed in R5 to R8 changes no output. The next command-channel byte is decoded as a new opcode.
- R10: In the prefix phase, a byte other than 0x80, 0xC0 or 0x40 is ignored and the parser stays in the prefix phase.
- R11: `txn_end` returns the parser to the prefix phase and drops any pending argument. A byte offered in the same cycle is handled first.
- R12: With `byte_vld` low, and for bytes read as prefixes, no output changes and `data_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | `byte_in` carries a payload byte this cycle |
| byte_in | input | 8 | Payload byte |
| txn_end | input | 1 | End of the current write transaction |
| disp_on | output | 1 | Panel enabled |
| all_on | output | 1 | All pixels forced lit |
| invert | output | 1 | Inverted video |
| scan_rev | output | 1 | Common lines scanned bottom to top |
| seg_rev | output | 1 | Segment order reversed |
| contrast | output | 8 | Brightness level |
| offset | output | OFS_W (6) | Vertical line shift |
| addr_mode | output | 2 | Addressing mode code |
| col_start | output | COL_W (7) | Column window start |
| col_end | output | COL_W (7) | Column window end |
| page_start | output | PAGE_W (3) | Page window start |
| page_end | output | PAGE_W (3) | Page window end |
| win_col_stb | output | 1 | Column window just loaded |
| win_page_stb | output | 1 | Page window just loaded |
| data_stb | output | 1 | Display data byte valid |
| data_byte | output | 8 | Display data byte, held between strobes |

## Verification
The assertions assume that `byte_vld` and `txn_end` are clean, defined levels sampled at the rising edge, and that at most one payload byte arrives per cycle. They make no assumption about byte values, about prefix order, or about whether an argument ever arrives.

The stimulus keeps within these assumptions by changing inputs only on the falling edge. Within that limit it deliberately mixes legal frames with stray prefixes, unknown opcodes, transactions cut off between an opcode and its arguments, and `txn_end` pulses with no byte. Every output is compared after every byte against a reference model kept in the bench.

// File: rtl/dci_pkg.sv
package dci_pkg;

   // Parser phase: what the next payload byte means
   typedef enum logic [1:0] {
      PH_CTRL   = 2'd0,
      PH_CMD    = 2'd1,
      PH_ONE    = 2'd2,
      PH_STREAM = 2'd3
   } phase_e;

   // Which argument the command channel is waiting for
   typedef enum logic [2:0] {
      PA_NONE    = 3'd0,
      PA_MODE    = 3'd1,
      PA_LEVEL   = 3'd2,
      PA_SHIFT   = 3'd3,
      PA_COL_LO  = 3'd4,
      PA_COL_HI  = 3'd5,
      PA_PAGE_LO = 3'd6,
      PA_PAGE_HI = 3'd7
   } pend_e;

   // Prefix values
   localparam logic [7:0] CTL_CMD    = 8'h80;
   localparam logic [7:0] CTL_ONE    = 8'hC0;
   localparam logic [7:0] CTL_STREAM = 8'h40;

   // Opcodes
   localparam logic [7:0] OP_SLEEP    = 8'hAE;
   localparam logic [7:0] OP_WAKE     = 8'hAF;
   localparam logic [7:0] OP_SHOW_RAM = 8'hA4;
   localparam logic [7:0] OP_ALL_LIT  = 8'hA5;
   localparam logic [7:0] OP_VID_NORM = 8'hA6;
   localparam logic [7:0] OP_VID_INV  = 8'hA7;
   localparam logic [7:0] OP_SCAN_FWD = 8'hC0;
   localparam logic [7:0] OP_SCAN_REV = 8'hC8;
   localparam logic [7:0] OP_SEG_FWD  = 8'hA0;
   localparam logic [7:0] OP_SEG_REV  = 8'hA1;
   localparam logic [7:0] OP_MODE     = 8'h20;
   localparam logic [7:0] OP_COLWIN   = 8'h21;
   localparam logic [7:0] OP_PAGEWIN  = 8'h22;
   localparam logic [7:0] OP_LEVEL    = 8'h81;
   localparam logic [7:0] OP_SHIFT    = 8'hD3;

endpackage

// File: rtl/dci_framer.sv
module dci_framer
   import dci_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   input  logic       txn_end,
   output logic       cmd_vld,
   output logic [7:0] cmd_byte,
   output logic       data_stb,
   output logic [7:0] data_byte
);

   phase_e phase_q, phase_d;
   logic   take_data;

   always_comb begin
      phase_d   = phase_q;
      cmd_vld   = 1'b0;
      take_data = 1'b0;
      if (byte_vld) begin
         case (phase_q)
            PH_CTRL: begin
               if (byte_in == CTL_CMD)         phase_d = PH_CMD;
               else if (byte_in == CTL_ONE)    phase_d = PH_ONE;
               else if (byte_in == CTL_STREAM) phase_d = PH_STREAM;
            end
            PH_CMD: begin
               cmd_vld = 1'b1;
               phase_d = PH_CTRL;
            end
            PH_ONE: begin
               take_data = 1'b1;
               phase_d   = PH_CTRL;
            end
            default: take_data = 1'b1;
         endcase
      end
      if (txn_end) phase_d = PH_CTRL;
   end

   assign cmd_byte = byte_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CTRL;
         data_stb  <= 1'b0;
         data_byte <= 8'h00;
      end else begin
         phase_q  <= phase_d;
         data_stb <= take_data;
         if (take_data) data_byte <= byte_in;
      end
   end

   // R11: a transaction end always leaves the parser in the prefix phase
   assert_end_to_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      txn_end |=> phase_q == PH_CTRL);

   // R12: a byte read as a prefix never yields data
   assert_prefix_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && phase_q == PH_CTRL) |=> !data_stb);

   // R12: no byte offered, no data strobe
   assert_idle_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> !data_stb);

   // R3: single data prefix consumes one byte then returns to prefix phase
   assert_one_then_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && phase_q == PH_ONE) |=> phase_q == PH_CTRL);

endmodule

// File: rtl/dci_decoder.sv
module dci_decoder
   import dci_pkg::*;
#(
   parameter int         OFS_W     = 6,
   parameter logic [7:0] LEVEL_RST = 8'h7F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vld,
   input  logic [7:0]       cmd_byte,
   input  logic             txn_end,
   output logic             disp_on,
   output logic             all_on,
   output logic             invert,
   output logic             scan_rev,
   output logic             seg_rev,
   output logic [7:0]       contrast,
   output logic [OFS_W-1:0] offset,
   output logic [1:0]       addr_mode,
   output logic             col_lo_we,
   output logic             col_hi_we,
   output logic             page_lo_we,
   output logic             page_hi_we
);

   pend_e pend_q, pend_d;
   logic  is_arg, is_op;

   assign is_arg = cmd_vld && (pend_q != PA_NONE);
   assign is_op  = cmd_vld && (pend_q == PA_NONE);

   always_comb begin
      pend_d     = pend_q;
      col_lo_we  = 1'b0;
      col_hi_we  = 1'b0;
      page_lo_we = 1'b0;
      page_hi_we = 1'b0;
      if (is_arg) begin
         case (pend_q)
            PA_COL_LO:  begin col_lo_we  = 1'b1; pend_d = PA_COL_HI;  end
            PA_COL_HI:  begin col_hi_we  = 1'b1; pend_d = PA_NONE;    end
            PA_PAGE_LO: begin page_lo_we = 1'b1; pend_d = PA_PAGE_HI; end
            PA_PAGE_HI: begin page_hi_we = 1'b1; pend_d = PA_NONE;    end
            default:    pend_d = PA_NONE;
         endcase
      end else if (is_op) begin
         case (cmd_byte)
            OP_MODE:    pend_d = PA_MODE;
            OP_LEVEL:   pend_d = PA_LEVEL;
            OP_SHIFT:   pend_d = PA_SHIFT;
            OP_COLWIN:  pend_d = PA_COL_LO;
            OP_PAGEWIN: pend_d = PA_PAGE_LO;
            default:    pend_d = pend_q;
         endcase
      end
      if (txn_end) pend_d = PA_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= PA_NONE;
         disp_on   <= 1'b0;
         all_on    <= 1'b0;
         invert    <= 1'b0;
         scan_rev  <= 1'b0;
         seg_rev   <= 1'b0;
         contrast  <= LEVEL_RST;
         offset    <= '0;
         addr_mode <= 2'd0;
      end else begin
         pend_q <= pend_d;
         if (is_arg) begin
            case (pend_q)
               PA_MODE:  addr_mode <= cmd_byte[1:0];
               PA_LEVEL: contrast  <= cmd_byte;
               PA_SHIFT: offset    <= cmd_byte[OFS_W-1:0];
               default:  ;
            endcase
         end
         if (is_op) begin
            case (cmd_byte)
               OP_SLEEP:    disp_on  <= 1'b0;
               OP_WAKE:     disp_on  <= 1'b1;
               OP_SHOW_RAM: all_on   <= 1'b0;
               OP_ALL_LIT:  all_on   <= 1'b1;
               OP_VID_NORM: invert   <= 1'b0;
               OP_VID_INV:  invert   <= 1'b1;
               OP_SCAN_FWD: scan_rev <= 1'b0;
               OP_SCAN_REV: scan_rev <= 1'b1;
               OP_SEG_FWD:  seg_rev  <= 1'b0;
               OP_SEG_REV:  seg_rev  <= 1'b1;
               default:     ;
            endcase
         end
      end
   end

   // R7: brightness moves only after a command-channel byte
   assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_vld) |-> $stable(contrast));

   // R11: a transaction end drops any pending argument
   assert_end_drops_arg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      txn_end |=> pend_q == PA_NONE);

   // R5: panel flag stays put without command traffic
   assert_power_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_vld) |-> $stable(disp_on));

   // R8: at most one window write enable at a time
   assert_one_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({col_lo_we, col_hi_we, page_lo_we, page_hi_we}));

endmodule

// File: rtl/dci_window.sv
module dci_window #(
   parameter int W      = 7,
   parameter bit ATOMIC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lo_we,
   input  logic         hi_we,
   input  logic [7:0]   din,
   output logic [W-1:0] start_o,
   output logic [W-1:0] end_o,
   output logic         stb_o
);

   localparam logic [W-1:0] END_RST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_o <= END_RST;
         stb_o <= 1'b0;
      end else begin
         stb_o <= hi_we;
         if (hi_we) end_o <= din[W-1:0];
      end
   end

   generate
      if (ATOMIC) begin : g_atomic
         logic [W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
               start_o <= '0;
            end else begin
               if (lo_we) stage_q <= din[W-1:0];
               if (hi_we) start_o <= stage_q;
            end
         end

         // R8: the start edge moves only together with the strobe
         assert_start_with_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(start_o) |-> stb_o);
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     start_o <= '0;
            else if (lo_we) start_o <= din[W-1:0];
         end
      end
   endgenerate

   // R8: an end argument is always followed by the strobe
   assert_end_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |=> stb_o);

   // R8: the end edge moves only together with the strobe
   assert_end_with_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(end_o) |-> stb_o);

endmodule

// File: rtl/dispcmd_interp.sv
module dispcmd_interp
   import dci_pkg::*;
#(
   parameter int         COL_W      = 7,
   parameter int         PAGE_W     = 3,
   parameter int         OFS_W      = 6,
   parameter logic [7:0] LEVEL_RST  = 8'h7F,
   parameter bit         WIN_ATOMIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   input  logic              txn_end,
   output logic              disp_on,
   output logic              all_on,
   output logic              invert,
   output logic              scan_rev,
   output logic              seg_rev,
   output logic [7:0]        contrast,
   output logic [OFS_W-1:0]  offset,
   output logic [1:0]        addr_mode,
   output logic [COL_W-1:0]  col_start,
   output logic [COL_W-1:0]  col_end,
   output logic [PAGE_W-1:0] page_start,
   output logic [PAGE_W-1:0] page_end,
   output logic              win_col_stb,
   output logic              win_page_stb,
   output logic              data_stb,
   output logic [7:0]        data_byte
);

   generate
      if (COL_W < 1 || COL_W > 8) begin : g_bad_col
         $error("COL_W must lie in 1..8");
      end
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("PAGE_W must lie in 1..8");
      end
      if (OFS_W < 1 || OFS_W > 8) begin : g_bad_ofs
         $error("OFS_W must lie in 1..8");
      end
   endgenerate

   logic       cmd_vld;
   logic [7:0] cmd_byte;
   logic       col_lo_we, col_hi_we, page_lo_we, page_hi_we;

   dci_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_in   (byte_in),
      .txn_end   (txn_end),
      .cmd_vld   (cmd_vld),
      .cmd_byte  (cmd_byte),
      .data_stb  (data_stb),
      .data_byte (data_byte)
   );

   dci_decoder #(
      .OFS_W     (OFS_W),
      .LEVEL_RST (LEVEL_RST)
   ) u_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_vld    (cmd_vld),
      .cmd_byte   (cmd_byte),
      .txn_end    (txn_end),
      .disp_on    (disp_on),
      .all_on     (all_on),
      .invert     (invert),
      .scan_rev   (scan_rev),
      .seg_rev    (seg_rev),
      .contrast   (contrast),
      .offset     (offset),
      .addr_mode  (addr_mode),
      .col_lo_we  (col_lo_we),
      .col_hi_we  (col_hi_we),
      .page_lo_we (page_lo_we),
      .page_hi_we (page_hi_we)
   );

   dci_window #(.W(COL_W), .ATOMIC(WIN_ATOMIC)) u_colwin (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (col_lo_we),
      .hi_we   (col_hi_we),
      .din     (cmd_byte),
      .start_o (col_start),
      .end_o   (col_end),
      .stb_o   (win_col_stb)
   );

   dci_window #(.W(PAGE_W), .ATOMIC(WIN_ATOMIC)) u_pagewin (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (page_lo_we),
      .hi_we   (page_hi_we),
      .din     (cmd_byte),
      .start_o (page_start),
      .end_o   (page_end),
      .stb_o   (win_page_stb)
   );

   // R2: one byte has one role: data and command effects never coincide
   assert_one_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_stb && (win_col_stb || win_page_stb)));

endmodule

// File: tb/tb_dispcmd_interp.sv
module tb_dispcmd_interp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       txn_end = 1'b0;

   logic       disp_on, all_on, invert, scan_rev, seg_rev;
   logic [7:0] contrast;
   logic [5:0] offset;
   logic [1:0] addr_mode;
   logic [6:0] col_start, col_end;
   logic [2:0] page_start, page_end;
   logic       win_col_stb, win_page_stb, data_stb;
   logic [7:0] data_byte;

   dispcmd_interp dut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in), .txn_end(txn_end),
      .disp_on(disp_on), .all_on(all_on), .invert(invert), .scan_rev(scan_rev),
      .seg_rev(seg_rev), .contrast(contrast), .offset(offset), .addr_mode(addr_mode),
      .col_start(col_start), .col_end(col_end), .page_start(page_start), .page_end(page_end),
      .win_col_stb(win_col_stb), .win_page_stb(win_page_stb),
      .data_stb(data_stb), .data_byte(data_byte)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model: phase 0 prefix, 1 command, 2 one data, 3 stream
   int m_ph, m_pend;
   logic       e_on, e_all, e_inv, e_scan, e_seg;
   logic [7:0] e_level, e_dbyte;
   logic [5:0] e_ofs;
   logic [1:0] e_mode;
   logic [6:0] e_cs, e_ce, e_cstage;
   logic [2:0] e_ps, e_pe, e_pstage;
   logic       e_cstb, e_pstb, e_dstb;

   task automatic model_reset();
      m_ph = 0; m_pend = 0;
      e_on = 0; e_all = 0; e_inv = 0; e_scan = 0; e_seg = 0;
      e_level = 8'h7F; e_ofs = 0; e_mode = 0; e_dbyte = 0;
      e_cs = 0; e_ce = 7'h7F; e_cstage = 0; e_ps = 0; e_pe = 3'h7; e_pstage = 0;
      e_cstb = 0; e_pstb = 0; e_dstb = 0;
   endtask

   task automatic model_cmd(input logic [7:0] b);
      if (m_pend != 0) begin
         case (m_pend)
            1: e_mode  = b[1:0];
            2: e_level = b;
            3: e_ofs   = b[5:0];
            4: e_cstage = b[6:0];
            5: begin e_cs = e_cstage; e_ce = b[6:0]; e_cstb = 1; end
            6: e_pstage = b[2:0];
            7: begin e_ps = e_pstage; e_pe = b[2:0]; e_pstb = 1; end
            default: ;
         endcase
         m_pend = (m_pend == 4) ? 5 : (m_pend == 6) ? 7 : 0;
      end else begin
         case (b)
            8'hAE: e_on = 0;   8'hAF: e_on = 1;
            8'hA4: e_all = 0;  8'hA5: e_all = 1;
            8'hA6: e_inv = 0;  8'hA7: e_inv = 1;
            8'hC0: e_scan = 0; 8'hC8: e_scan = 1;
            8'hA0: e_seg = 0;  8'hA1: e_seg = 1;
            8'h20: m_pend = 1; 8'h81: m_pend = 2; 8'hD3: m_pend = 3;
            8'h21: m_pend = 4; 8'h22: m_pend = 6;
            default: ;
         endcase
      end
   endtask

   task automatic model_byte(input logic [7:0] b, input bit e);
      e_cstb = 0; e_pstb = 0; e_dstb = 0;
      case (m_ph)
         0: begin
            if (b == 8'h80) m_ph = 1;
            else if (b == 8'hC0) m_ph = 2;
            else if (b == 8'h40) m_ph = 3;
         end
         1: begin model_cmd(b); m_ph = 0; end
         2: begin e_dstb = 1; e_dbyte = b; m_ph = 0; end
         default: begin e_dstb = 1; e_dbyte = b; end
      endcase
      if (e) begin m_ph = 0; m_pend = 0; end
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "disp_on", {31'd0, disp_on}, {31'd0, e_on});
      chk(tag, "all_on", {31'd0, all_on}, {31'd0, e_all});
      chk(tag, "invert", {31'd0, invert}, {31'd0, e_inv});
      chk(tag, "scan_rev", {31'd0, scan_rev}, {31'd0, e_scan});
      chk(tag, "seg_rev", {31'd0, seg_rev}, {31'd0, e_seg});
      chk(tag, "contrast", {24'd0, contrast}, {24'd0, e_level});
      chk(tag, "offset", {26'd0, offset}, {26'd0, e_ofs});
      chk(tag, "addr_mode", {30'd0, addr_mode}, {30'd0, e_mode});
      chk(tag, "col_start", {25'd0, col_start}, {25'd0, e_cs});
      chk(tag, "col_end", {25'd0, col_end}, {25'd0, e_ce});
      chk(tag, "page_start", {29'd0, page_start}, {29'd0, e_ps});
      chk(tag, "page_end", {29'd0, page_end}, {29'd0, e_pe});
      chk(tag, "win_col_stb", {31'd0, win_col_stb}, {31'd0, e_cstb});
      chk(tag, "win_page_stb", {31'd0, win_page_stb}, {31'd0, e_pstb});
      chk(tag, "data_stb", {31'd0, data_stb}, {31'd0, e_dstb});
      chk(tag, "data_byte", {24'd0, data_byte}, {24'd0, e_dbyte});
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic send(input logic [7:0] b, input bit e, input string tag);
      byte_in = b; byte_vld = 1'b1; txn_end = e;
      model_byte(b, e);
      @(posedge clk);
      @(negedge clk);
      byte_vld = 1'b0; txn_end = 1'b0;
      chk_all(tag);
   endtask

   task automatic end_only(input string tag);
      byte_vld = 1'b0; txn_end = 1'b1; byte_in = $urandom();
      e_cstb = 0; e_pstb = 0; e_dstb = 0; m_ph = 0; m_pend = 0;
      @(posedge clk);
      @(negedge clk);
      txn_end = 1'b0;
      chk_all(tag);
   endtask

   task automatic idle(input string tag);
      byte_vld = 1'b0; byte_in = $urandom();
      e_cstb = 0; e_pstb = 0; e_dstb = 0;
      @(posedge clk);
      @(negedge clk);
      chk_all(tag);
   endtask

   task automatic cmd(input logic [7:0] op, input string tag);
      send(8'h80, 1'b0, tag);
      send(op, 1'b0, tag);
   endtask

   function automatic logic [7:0] pick_op();
      case ($urandom_range(0, 17))
         0: return 8'hAE;  1: return 8'hAF;  2: return 8'hA4;  3: return 8'hA5;
         4: return 8'hA6;  5: return 8'hA7;  6: return 8'hC0;  7: return 8'hC8;
         8: return 8'hA0;  9: return 8'hA1;  10: return 8'h20; 11: return 8'h81;
         12: return 8'hD3; 13: return 8'h21; 14: return 8'h22; 15: return 8'h40;
         16: return 8'h80;
         default: return 8'($urandom());
      endcase
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1");

      // R5 and R2: single-byte display flags
      cmd(8'hAF, "R5"); cmd(8'hA5, "R5"); cmd(8'hA7, "R5");
      cmd(8'hA4, "R5"); cmd(8'hA6, "R2");
      // R6: orientation, 0xC0 here is an opcode, not a prefix
      cmd(8'hC8, "R6"); cmd(8'hA1, "R6"); cmd(8'hC0, "R6"); cmd(8'hA0, "R6");
      // R7: one-argument commands, offset masked to 6 bits
      cmd(8'h81, "R7"); cmd(8'h33, "R7");
      cmd(8'hD3, "R7"); cmd(8'hFF, "R7");
      cmd(8'h20, "R7"); cmd(8'h01, "R7");
      // R8: windows, start must not move after the first argument
      cmd(8'h21, "R8"); cmd(8'h10, "R8"); cmd(8'hFF, "R8");
      cmd(8'h22, "R8"); cmd(8'h02, "R8"); cmd(8'h05, "R8");
      // R3: single data byte then prefix again
      send(8'hC0, 1'b0, "R3"); send(8'h5A, 1'b0, "R3");
      cmd(8'hAE, "R3");
      // R4: stream carries prefix-looking bytes as data
      send(8'h40, 1'b0, "R4"); send(8'h11, 1'b0, "R4");
      send(8'h80, 1'b0, "R4"); send(8'hAF, 1'b1, "R4");
      cmd(8'hAF, "R11");
      // R9: unknown opcode, next command byte is a fresh opcode
      cmd(8'hE3, "R9"); cmd(8'hAE, "R9");
      // R10: stray prefix, following byte is a prefix too
      send(8'h12, 1'b0, "R10"); send(8'hAF, 1'b0, "R10");
      send(8'h00, 1'b0, "R10");
      // R11: end drops pending argument
      send(8'h80, 1'b0, "R11"); send(8'h81, 1'b1, "R11");
      cmd(8'h55, "R11");
      send(8'h80, 1'b0, "R11"); end_only("R11");
      send(8'hAF, 1'b0, "R11");
      send(8'h40, 1'b0, "R11"); end_only("R11"); send(8'h80, 1'b0, "R11");
      send(8'hA7, 1'b0, "R11");
      // R12: idle cycles
      for (int i = 0; i < 4; i++) idle("R12");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit e;
         e = ($urandom_range(0, 9) == 0);
         case ($urandom_range(0, 7))
            0, 1, 2: begin send(8'h80, 1'b0, "R2"); send(pick_op(), e, "R5"); end
            3: begin send(8'hC0, 1'b0, "R3"); send(8'($urandom()), e, "R3"); end
            4: begin
               send(8'h40, 1'b0, "R4");
               for (int j = 0; j < 4; j++) send(8'($urandom()), (j == 3), "R4");
            end
            5: send(8'($urandom()), e, "R10");
            6: end_only("R11");
            default: idle("R12");
         endcase
      end
      summary();
   end

endmodule